// File: doc/BRIEF.md
# LCD Power-Up Script and Command Sequencer

This block drives a monochrome graphic LCD controller over an 8-bit parallel bus with 6800-style timing. The bus has an active-low chip select, a register-select line (low for a command byte, high for a data byte), an enable strobe and a read/write line. The block only writes, so the read/write line is held at write.

After reset the block walks a small command ROM and writes each stored byte to the panel as a command. Each ROM entry carries a flag that inserts a long pause after the byte is written. The script uses this flag on the byte that switches the panel supply on, which gives a settling time of at least one millisecond. Bytes that belong to one two-byte instruction, such as a mode byte and the value that follows it, are sent with only the fixed fetch gap between them.

When the last script byte has been written, the block drops its busy flag and opens a user port. The user port takes a byte and a command/data flag through a valid/ready handshake. The setup, strobe and hold phases are counted in clock cycles, so the timing holds at any clock rate the parameters describe.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is applied and in the cycle after it, lcd_cs_n is 1, lcd_e is 0, lcd_rw is 0, busy is 1 and usr_ready is 0.
- R2: After reset the block writes the script bytes in this order, each with lcd_rs = 0: 0xE2, 0xA0, 0xC0, 0xA2, 0x2F, 0x81, 0x20, 0xAC, 0x00, 0x40, 0xAF. The sequence covers software reset, normal segment direction, normal common scan, 1/65-duty bias, power on, the reference-voltage pair, the static-indicator pair, start line 0 and display on. No other byte is written during the script.
- R3: In each bus cycle, lcd_cs_n is low with lcd_e low for exactly T_AS cycles before lcd_e rises. lcd_e then stays high for exactly max(T_EH, T_DS) cycles. After lcd_e falls, lcd_cs_n stays low for exactly T_AH cycles. lcd_db and lcd_rs do not change while lcd_cs_n is low, and lcd_rw is always 0.
- R4: After the script byte whose entry carries the pause flag (0x2F), lcd_cs_n stays high for at least CLK_MHZ*WAIT_US cycles before the next bus cycle starts.
- R5: Between any other two consecutive script bytes, lcd_cs_n is high for at most 4 cycles. This keeps two-byte instructions back to back.
- R6: busy stays 1 until the bus cycle of the last script byte has ended. It then goes to 0 and never returns to 1 until the next reset.
- R7: usr_ready is 0 while busy is 1 and while a bus cycle is in progress. usr_valid asserted while usr_ready is 0 starts no bus cycle.
- R8: Each accepted user transfer (usr_valid and usr_ready both 1 at a clock edge) produces exactly one bus cycle, with lcd_db = usr_byte and lcd_rs = usr_rs (1 = data, 0 = command).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_valid | input | 1 | User byte offered |
| usr_rs | input | 1 | User byte kind: 1 data, 0 command |
| usr_byte | input | 8 | User byte value |
| usr_ready | output | 1 | User byte can be taken this cycle |
| busy | output | 1 | Power-up script still running |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_rs | output | 1 | Panel register select: 1 data, 0 command |
| lcd_rw | output | 1 | Panel read/write, held at 0 (write) |
| lcd_e | output | 1 | Panel enable strobe |
| lcd_db | output | 8 | Panel data bus |

## Verification
The assertions assume that usr_byte and usr_rs stay steady whenever usr_valid is high at a clock edge. They also assume that reset is held for at least one clock edge at the start, so the ROM output register holds the first entry before the walk begins. The stimulus changes user inputs only on falling clock edges. It holds usr_valid high during the script to exercise the ignore rule, then drops it well before busy falls. It then offers user bytes only while usr_ready is seen high, and keeps them steady until the accepting edge has passed. The wait length is shortened by parameter so that the pause can be measured in full.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int unsigned SCRIPT_LEN = 11;

  typedef struct packed {
    logic       pause;  // hold off the next byte by the long wait
    logic [7:0] code;   // command byte sent with rs = 0
  } script_entry_t;

  typedef enum logic [2:0] {
    SQ_FETCH,
    SQ_LOAD,
    SQ_BUS,
    SQ_PAUSE,
    SQ_USER,
    SQ_UBUS
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } bus_phase_t;

  function automatic script_entry_t script_at(input int unsigned idx);
    script_entry_t e;
    e.pause = 1'b0;
    case (idx)
      0:  e.code = 8'hE2;                     // software reset
      1:  e.code = 8'hA0;                     // segment direction normal
      2:  e.code = 8'hC0;                     // common scan normal
      3:  e.code = 8'hA2;                     // bias for 1/65 duty
      4:  begin e.code = 8'h2F; e.pause = 1'b1; end // supply on, then settle
      5:  e.code = 8'h81;                     // reference voltage mode
      6:  e.code = 8'h20;                     // reference voltage value
      7:  e.code = 8'hAC;                     // static indicator mode
      8:  e.code = 8'h00;                     // static indicator value
      9:  e.code = 8'h40;                     // first display line 0
      10: e.code = 8'hAF;                     // display on
      default: e.code = 8'hE3;                // no-op
    endcase
    return e;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_init_rom.sv
module lcd_init_rom
  import lcd_seq_pkg::*;
#(
  parameter int unsigned DEPTH = SCRIPT_LEN,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  output script_entry_t q
);

  // Registered read so the table maps onto a block memory output register.
  always_ff @(posedge clk) begin
    q <= script_at(int'(addr));
  end

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(addr) < DEPTH);

endmodule

// File: rtl/lcd_bus_cycle.sv
module lcd_bus_cycle
  import lcd_seq_pkg::*;
#(
  parameter int unsigned T_AS = 2,
  parameter int unsigned T_EH = 3,
  parameter int unsigned T_DS = 2,
  parameter int unsigned T_AH = 1,
  localparam int unsigned T_STROBE = max2(T_EH, T_DS),
  localparam int unsigned T_MAX = max2(max2(T_AS, T_STROBE), T_AH),
  localparam int unsigned CW = $clog2(T_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       start_rs,
  input  logic [7:0] start_byte,
  output logic       idle,
  output logic       done,
  output logic       lcd_cs_n,
  output logic       lcd_rs,
  output logic       lcd_e,
  output logic [7:0] lcd_db
);

  bus_phase_t    phase;
  logic [CW-1:0] cnt;

  assign idle = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      lcd_cs_n <= 1'b1;
      lcd_rs   <= 1'b0;
      lcd_e    <= 1'b0;
      lcd_db   <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            lcd_cs_n <= 1'b0;
            lcd_rs   <= start_rs;
            lcd_db   <= start_byte;
            cnt      <= CW'(T_AS - 1);
            phase    <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            lcd_e <= 1'b1;
            cnt   <= CW'(T_STROBE - 1);
            phase <= PH_STROBE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            lcd_e <= 1'b0;
            cnt   <= CW'(T_AH - 1);
            phase <= PH_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            lcd_cs_n <= 1'b1;
            done     <= 1'b1;
            phase    <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // R3
  strobe_inside_select_chk: assert property (@(posedge clk) disable iff (rst)
    lcd_e |-> !lcd_cs_n);

  // R3
  bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!lcd_cs_n && $past(!lcd_cs_n)) |-> ($stable(lcd_db) && $stable(lcd_rs)));

  // R3
  release_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_cs_n) |-> !$past(lcd_e));

  // R8
  start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> lcd_cs_n);

endmodule

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int unsigned WAIT_CYC = 100000,
  localparam int unsigned CW = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);

  logic          running;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !running) begin
        running <= 1'b1;
        cnt     <= CW'(WAIT_CYC - 1);
      end else if (running) begin
        if (cnt == '0) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R4
  done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(running));

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned WAIT_US = 1000,
  parameter int unsigned T_AS    = 2,
  parameter int unsigned T_EH    = 3,
  parameter int unsigned T_DS    = 2,
  parameter int unsigned T_AH    = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       usr_valid,
  input  logic       usr_rs,
  input  logic [7:0] usr_byte,
  output logic       usr_ready,
  output logic       busy,
  output logic       lcd_cs_n,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db
);

  localparam int unsigned WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int unsigned AW = (SCRIPT_LEN > 1) ? $clog2(SCRIPT_LEN) : 1;

  seq_state_t    state;
  logic [AW-1:0] idx;
  script_entry_t rom_q;
  logic          bus_start, bus_rs, bus_idle, bus_done;
  logic [7:0]    bus_byte;
  logic          wait_start, wait_done;
  logic          last_entry, accept;

  assign lcd_rw     = 1'b0;
  assign last_entry = (int'(idx) == SCRIPT_LEN - 1);
  assign accept     = (state == SQ_USER) && usr_ready && usr_valid;
  assign bus_start  = (state == SQ_LOAD) || accept;
  assign bus_rs     = (state == SQ_LOAD) ? 1'b0 : usr_rs;
  assign bus_byte   = (state == SQ_LOAD) ? rom_q.code : usr_byte;
  assign wait_start = (state == SQ_BUS) && bus_done && rom_q.pause;

  lcd_init_rom #(.DEPTH(SCRIPT_LEN)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (idx),
    .q    (rom_q)
  );

  lcd_bus_cycle #(.T_AS(T_AS), .T_EH(T_EH), .T_DS(T_DS), .T_AH(T_AH)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .start      (bus_start),
    .start_rs   (bus_rs),
    .start_byte (bus_byte),
    .idle       (bus_idle),
    .done       (bus_done),
    .lcd_cs_n   (lcd_cs_n),
    .lcd_rs     (lcd_rs),
    .lcd_e      (lcd_e),
    .lcd_db     (lcd_db)
  );

  lcd_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk   (clk),
    .rst   (rst),
    .start (wait_start),
    .done  (wait_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_FETCH;
      idx       <= '0;
      busy      <= 1'b1;
      usr_ready <= 1'b0;
    end else begin
      case (state)
        SQ_FETCH: state <= SQ_LOAD;
        SQ_LOAD:  state <= SQ_BUS;
        SQ_BUS: begin
          if (bus_done) begin
            if (rom_q.pause) begin
              state <= SQ_PAUSE;
            end else if (last_entry) begin
              state     <= SQ_USER;
              busy      <= 1'b0;
              usr_ready <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= SQ_FETCH;
            end
          end
        end
        SQ_PAUSE: begin
          if (wait_done) begin
            if (last_entry) begin
              state     <= SQ_USER;
              busy      <= 1'b0;
              usr_ready <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= SQ_FETCH;
            end
          end
        end
        SQ_USER: begin
          if (accept) begin
            usr_ready <= 1'b0;
            state     <= SQ_UBUS;
          end
        end
        default: begin
          if (bus_done) begin
            usr_ready <= 1'b1;
            state     <= SQ_USER;
          end
        end
      endcase
    end
  end

  // R7
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    usr_ready |-> !busy);

  // R7
  ready_bus_free_chk: assert property (@(posedge clk) disable iff (rst)
    usr_ready |-> (lcd_cs_n && bus_idle));

  // R6
  busy_never_returns_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);

  // R4
  pause_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_PAUSE) |-> lcd_cs_n);

endmodule

// File: tb/sim_lcd_init_seq.sv
module sim_lcd_init_seq;

  localparam int T_AS = 2, T_EH = 3, T_DS = 4, T_AH = 1;
  localparam int CLK_MHZ = 100, WAIT_US = 3;
  localparam int STROBE = (T_EH > T_DS) ? T_EH : T_DS;
  localparam int WAITC = CLK_MHZ * WAIT_US;
  localparam int NSCRIPT = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic usr_valid = 1'b0, usr_rs = 1'b0;
  logic [7:0] usr_byte = '0;
  logic usr_ready, busy, lcd_cs_n, lcd_rs, lcd_rw, lcd_e;
  logic [7:0] lcd_db;

  int compared = 0, mismatched = 0;
  bit done_flag = 0;
  logic [8:0] expq[$];

  always #5 clk = ~clk;

  lcd_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .T_AS(T_AS),
                 .T_EH(T_EH), .T_DS(T_DS), .T_AH(T_AH)) u0 (
    .clk(clk), .rst(rst), .usr_valid(usr_valid), .usr_rs(usr_rs),
    .usr_byte(usr_byte), .usr_ready(usr_ready), .busy(busy),
    .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
    .lcd_db(lcd_db));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input bit rs, input logic [7:0] b);
    @(negedge clk);
    usr_valid = 1'b1; usr_rs = rs; usr_byte = b;
    while (!usr_ready) @(negedge clk);
    expq.push_back({rs, b});
    @(negedge clk);
    usr_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  int setup_c = 0, high_c = 0, hold_c = 0, gap_c = 0, seen = 0;
  logic prev_cs = 1'b1, prev_e = 1'b0;
  logic [7:0] last_byte = '0, cyc_db = '0;
  logic cyc_rs = 1'b0;
  bit stable_ok = 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (usr_ready && (busy || !lcd_cs_n))
        chk(0, "R7 ready while busy/bus", usr_ready, 0);
      if (lcd_rw !== 1'b0) chk(0, "R3 rw", lcd_rw, 0);
      if (!lcd_cs_n && prev_cs) begin
        // cycle start: gap checks
        if (seen > 0 && seen < NSCRIPT) begin
          if (last_byte == 8'h2F)
            chk(gap_c >= WAITC, "R4 pause length", gap_c, WAITC);
          else
            chk(gap_c <= 4, "R5 back-to-back gap", gap_c, 4);
        end
        setup_c = 0; high_c = 0; hold_c = 0; stable_ok = 1;
        cyc_db = lcd_db; cyc_rs = lcd_rs;
      end
      if (!lcd_cs_n) begin
        if (lcd_db !== cyc_db || lcd_rs !== cyc_rs) stable_ok = 0;
        if (lcd_e) high_c++;
        else if (high_c == 0) setup_c++;
        else hold_c++;
      end
      if (prev_e && !lcd_e) begin
        chk(setup_c == T_AS, "R3 setup", setup_c, T_AS);
        chk(high_c == STROBE, "R3 strobe width", high_c, STROBE);
        if (expq.size() == 0) begin
          chk(0, "R2/R7/R8 unexpected byte", {lcd_rs, lcd_db}, 0);
        end else begin
          logic [8:0] ex;
          ex = expq.pop_front();
          chk({lcd_rs, lcd_db} == ex, (seen < NSCRIPT) ? "R2 script byte" : "R8 user byte",
              {lcd_rs, lcd_db}, ex);
        end
        if (seen < NSCRIPT) chk(busy == 1'b1, "R6 busy during script", busy, 1);
        last_byte = lcd_db;
        seen++;
      end
      if (lcd_cs_n && !prev_cs) begin
        chk(hold_c == T_AH, "R3 hold", hold_c, T_AH);
        chk(stable_ok, "R3 bus stable", stable_ok, 1);
        gap_c = 0;
      end
      if (lcd_cs_n) gap_c++;
      prev_cs = lcd_cs_n; prev_e = lcd_e;
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] script [NSCRIPT] = '{8'hE2, 8'hA0, 8'hC0, 8'hA2, 8'h2F, 8'h81,
                                     8'h20, 8'hAC, 8'h00, 8'h40, 8'hAF};
    foreach (script[i]) expq.push_back({1'b0, script[i]});
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(lcd_cs_n == 1 && lcd_e == 0 && lcd_rw == 0, "R1 bus idle in reset",
        {lcd_cs_n, lcd_e, lcd_rw}, 3'b100);
    chk(busy == 1 && usr_ready == 0, "R1 busy/ready in reset", {busy, usr_ready}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    chk(lcd_cs_n == 1 && lcd_e == 0 && busy == 1 && usr_ready == 0,
        "R1 first cycle after reset", {lcd_cs_n, lcd_e, busy, usr_ready}, 4'b1010);
    // R7: offer user data during the script; it must be ignored
    usr_valid = 1'b1; usr_rs = 1'b1; usr_byte = 8'h55;
    repeat (60) @(negedge clk);
    chk(usr_ready == 0, "R7 ready low during script", usr_ready, 0);
    usr_valid = 1'b0;
    while (busy) @(negedge clk);
    chk(seen == NSCRIPT, "R6 busy falls after last script byte", seen, NSCRIPT);
    chk(expq.size() == 0, "R2 whole script sent", expq.size(), 0);
    @(negedge clk);
    chk(usr_ready == 1, "R7 ready after script", usr_ready, 1);
    // R8 user transfers
    send(1'b1, 8'hA5);
    send(1'b0, 8'hB0);
    send(1'b1, 8'h00);
    send(1'b1, 8'hFF);
    repeat (30) @(negedge clk);
    chk(expq.size() == 0, "R8 all user bytes written", expq.size(), 0);
    chk(seen == NSCRIPT + 4, "R8 one cycle per accept", seen, NSCRIPT + 4);
    chk(busy == 0, "R6 busy stays low", busy, 0);
    finish_run();
  end

endmodule